// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs single-byte external accesses over eight shared lines that carry first an address and then data. An internal requester presents a request together with a direction, an address byte, a write byte and an area number. When the block is idle and the area permits multiplexed operation, it starts the access. Two address states put the address on the shared lines and pulse an address-hold strobe so that outside logic can latch it. Two data states then move the byte in the requested direction.

The controller is a five-state machine. ST_IDLE goes to ST_TMA1 on an accepted request, that is, a request whose area is multiplexed. All other states advance unconditionally: ST_TMA1 to ST_TMA2 (address phase), ST_TMA2 to ST_T1 (start of data phase), ST_T1 to ST_T2, and ST_T2 back to ST_IDLE (completion). A one-cycle done pulse and a busy level form the handshake toward the requester. All strobes are active low.

Top module: `muxbus_master`

## Requirements
- R1: After reset the block is idle: busy_o and done_o are 0, every cs_n_o bit, ah_n_o, rd_n_o, lwr_n_o and bs_n_o are 1, and rdwr_o is 1.
- R2: An accepted request moves the block through ST_TMA1, ST_TMA2, ST_T1 and ST_T2 on the four following clock cycles. busy_o is 1 for exactly those four cycles. done_o is 1 for the single cycle after ST_T2.
- R3: The captured address appears on data_io during ST_TMA1 and ST_TMA2. ah_n_o is 0 in ST_TMA1 only.
- R4: cs_n_o bit k (k = area number) is 0 from ST_TMA1 through ST_T2 and 1 otherwise. All other bits stay 1.
- R5: bs_n_o is 0 in ST_T1 only.
- R6: On a read (we_i = 0), rd_n_o is 0 in ST_T1 and ST_T2. The block releases data_io during the data phase. rdata_o holds the data_io value sampled at the end of ST_T2, and it is valid from the done_o cycle.
- R7: On a write (we_i = 1), the captured write byte is on data_io in ST_T1 and ST_T2. lwr_n_o is 0 in ST_T2 only. rdwr_o is 0 from ST_TMA1 through ST_T2. On reads rdwr_o stays 1.
- R8: A request whose area is 0, 1 or 2 is ignored: the block stays idle and no chip select falls.
- R9: Requests and input changes during an access are ignored. The access uses the values captured when it was accepted.
- R10: A request presented in the done_o cycle is accepted, so a new ST_TMA1 follows directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bus state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled in ST_IDLE |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Address byte |
| wdata_i | input | 8 | Write byte |
| area_i | input | 3 | Target area number |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last read byte |
| cs_n_o | output | 8 | Per-area chip selects, active low |
| ah_n_o | output | 1 | Address-hold strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| lwr_n_o | output | 1 | Low-byte write strobe, active low |
| bs_n_o | output | 1 | Bus-start strobe, active low |
| rdwr_o | output | 1 | Direction: 1 read, 0 write |
| data_io | inout | 8 | Shared address/data lines |

## Verification
The assertions assume that the outside device drives data_io only while rd_n_o is low, so the shared lines never see two drivers. The bench's responder drives the read byte exactly under that condition and releases the lines otherwise. The assertions also assume that the requester holds its inputs steady only up to acceptance. The stimulus deliberately breaks that assumption in the middle of an access, asserting the request again and changing every input, to show that the captured values are kept.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TMA1,
        ST_TMA2,
        ST_T1,
        ST_T2
    } mbus_state_t;
endpackage

// File: rtl/muxbus_fsm.sv
module muxbus_fsm
    import muxbus_pkg::*;
#(
    parameter int AREA_W = 3,
    parameter int MUX_LO = 3,
    parameter int MUX_HI = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [AREA_W-1:0] area,
    output mbus_state_t       state,
    output logic              accept,
    output logic              done
);
    localparam int NUM_AREA = 1 << AREA_W;

    function automatic logic [NUM_AREA-1:0] build_mask();
        logic [NUM_AREA-1:0] m;
        for (int i = 0; i < NUM_AREA; i++) m[i] = (i >= MUX_LO) && (i <= MUX_HI);
        return m;
    endfunction

    localparam logic [NUM_AREA-1:0] MUX_MASK = build_mask();

    mbus_state_t state_nx;

    assign accept = (state == ST_IDLE) && req && MUX_MASK[area];

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_TMA1;
            ST_TMA1: state_nx = ST_TMA2;
            ST_TMA2: state_nx = ST_T1;
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_T2);
        end
    end

    assert_tma1_to_tma2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_TMA1 |=> state == ST_TMA2);
    assert_tma2_to_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_TMA2 |=> state == ST_T1);
    assert_t1_to_t2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T1 |=> state == ST_T2);
    assert_t2_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T2 |=> (state == ST_IDLE && done));
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/muxbus_strobes.sv
module muxbus_strobes
    import muxbus_pkg::*;
#(
    parameter int AREA_W = 3,
    parameter int MUX_LO = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  mbus_state_t              state,
    input  logic                     we_q,
    input  logic [AREA_W-1:0]        area_q,
    output logic [(1<<AREA_W)-1:0]   cs_n,
    output logic                     ah_n,
    output logic                     rd_n,
    output logic                     lwr_n,
    output logic                     bs_n,
    output logic                     rdwr,
    output logic                     oe,
    output logic                     sel_addr
);
    always_comb begin
        cs_n     = '1;
        ah_n     = 1'b1;
        rd_n     = 1'b1;
        lwr_n    = 1'b1;
        bs_n     = 1'b1;
        rdwr     = 1'b1;
        oe       = 1'b0;
        sel_addr = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_TMA1: begin
                cs_n[area_q] = 1'b0;
                ah_n         = 1'b0;
                rdwr         = ~we_q;
                oe           = 1'b1;
                sel_addr     = 1'b1;
            end
            ST_TMA2: begin
                cs_n[area_q] = 1'b0;
                rdwr         = ~we_q;
                oe           = 1'b1;
                sel_addr     = 1'b1;
            end
            ST_T1: begin
                cs_n[area_q] = 1'b0;
                bs_n         = 1'b0;
                rd_n         = we_q;
                rdwr         = ~we_q;
                oe           = we_q;
            end
            ST_T2: begin
                cs_n[area_q] = 1'b0;
                rd_n         = we_q;
                lwr_n        = ~we_q;
                rdwr         = ~we_q;
                oe           = we_q;
            end
            default: ;
        endcase
    end

    assert_ah_one_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ah_n |=> (ah_n && sel_addr));
    assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    assert_cs_low_areas_R8: assert property (@(posedge clk) disable iff (!rst_n)
        &cs_n[MUX_LO-1:0]);
    assert_bs_after_ah_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bs_n |-> $past(!ah_n, 2));
    assert_rd_lwr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !lwr_n));
    assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !oe);
endmodule

// File: rtl/muxbus_datapath.sv
module muxbus_datapath
    import muxbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AREA_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mbus_state_t       state,
    input  logic              accept,
    input  logic              sel_addr,
    input  logic              we_i,
    input  logic [DATA_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AREA_W-1:0] area_i,
    input  logic [DATA_W-1:0] din,
    output logic              we_q,
    output logic [AREA_W-1:0] area_q,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            area_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (accept) begin
                we_q    <= we_i;
                area_q  <= area_i;
                addr_q  <= addr_i;
                wdata_q <= wdata_i;
            end
            if (state == ST_T2 && !we_q) rdata <= din;
        end
    end

    assign dout = sel_addr ? addr_q : wdata_q;

    assert_capture_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(addr_q) && $stable(wdata_q) && $stable(we_q));
    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_T2) |=> $stable(rdata));
endmodule

// File: rtl/muxbus_master.sv
module muxbus_master
    import muxbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AREA_W = 3,
    parameter int MUX_LO = 3,
    parameter int MUX_HI = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  logic                   we_i,
    input  logic [DATA_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [AREA_W-1:0]      area_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [DATA_W-1:0]      rdata_o,
    output logic [(1<<AREA_W)-1:0] cs_n_o,
    output logic                   ah_n_o,
    output logic                   rd_n_o,
    output logic                   lwr_n_o,
    output logic                   bs_n_o,
    output logic                   rdwr_o,
    inout  wire  [DATA_W-1:0]      data_io
);
    mbus_state_t       state;
    logic              accept;
    logic              we_q;
    logic [AREA_W-1:0] area_q;
    logic              oe;
    logic              sel_addr;
    logic [DATA_W-1:0] dout;

    muxbus_fsm #(.AREA_W(AREA_W), .MUX_LO(MUX_LO), .MUX_HI(MUX_HI)) fsm_i (
        .clk(clk), .rst_n(rst_n), .req(req_i), .area(area_i),
        .state(state), .accept(accept), .done(done_o)
    );

    muxbus_strobes #(.AREA_W(AREA_W), .MUX_LO(MUX_LO)) strobes_i (
        .clk(clk), .rst_n(rst_n), .state(state), .we_q(we_q), .area_q(area_q),
        .cs_n(cs_n_o), .ah_n(ah_n_o), .rd_n(rd_n_o), .lwr_n(lwr_n_o),
        .bs_n(bs_n_o), .rdwr(rdwr_o), .oe(oe), .sel_addr(sel_addr)
    );

    muxbus_datapath #(.DATA_W(DATA_W), .AREA_W(AREA_W)) datapath_i (
        .clk(clk), .rst_n(rst_n), .state(state), .accept(accept),
        .sel_addr(sel_addr), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .area_i(area_i), .din(data_io), .we_q(we_q), .area_q(area_q),
        .dout(dout), .rdata(rdata_o)
    );

    assign busy_o  = (state != ST_IDLE);
    assign data_io = oe ? dout : 'z;

    assert_busy_needs_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(&cs_n_o));
    assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/muxbus_master_tb.sv
`timescale 1ns/1ps
module muxbus_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, we = 1'b0;
    logic [7:0] addr = '0, wdata = '0, rd_val = '0;
    logic [2:0] area = '0;
    logic       busy, done, ah_n, rd_n, lwr_n, bs_n, rdwr;
    logic [7:0] rdata, cs_n;
    wire  [7:0] data_bus;

    int checks = 0, errors = 0, issued = 0, seen = 0;

    typedef struct {
        bit         w;
        logic [7:0] a, wd, rv;
        logic [2:0] ar;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    assign data_bus = !rd_n ? rd_val : 'z;

    muxbus_master dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .area_i(area), .busy_o(busy), .done_o(done),
        .rdata_o(rdata), .cs_n_o(cs_n), .ah_n_o(ah_n), .rd_n_o(rd_n),
        .lwr_n_o(lwr_n), .bs_n_o(bs_n), .rdwr_o(rdwr), .data_io(data_bus)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic issue(bit w, logic [7:0] a, logic [7:0] wd, logic [7:0] rv,
                         logic [2:0] ar, bit poke);
        item_t it;
        it.w = w; it.a = a; it.wd = wd; it.rv = rv; it.ar = ar;
        exp_q.push_back(it);
        issued++;
        req = 1'b1; we = w; addr = a; wdata = wd; area = ar; rd_val = rv;
        @(negedge clk);
        req = 1'b0;
        if (poke) begin
            // R9: new request and changed inputs mid-access
            @(negedge clk);
            req = 1'b1; we = ~w; addr = ~a; wdata = ~wd; area = (ar == 3'd5) ? 3'd4 : 3'd5;
            @(negedge clk);
            req = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !ah_n) begin
                item_t it;
                logic [7:0] cs_exp;
                seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected access", 1, 0);
                    continue;
                end
                it = exp_q.pop_front();
                cs_exp = ~(8'h01 << it.ar);
                // ST_TMA1
                chk(cs_n == cs_exp, "R4 cs in TMA1", cs_n, cs_exp);
                chk(data_bus == it.a, "R3 addr in TMA1", data_bus, it.a);
                chk(rdwr == !it.w, "R7 rdwr in TMA1", rdwr, !it.w);
                chk(busy && bs_n && rd_n && lwr_n, "R2 strobes in TMA1", {busy, bs_n, rd_n, lwr_n}, 4'hF);
                @(negedge clk);
                // ST_TMA2
                chk(ah_n == 1'b1, "R3 ah released in TMA2", ah_n, 1);
                chk(data_bus == it.a, "R3 addr in TMA2", data_bus, it.a);
                chk(cs_n == cs_exp, "R4 cs in TMA2", cs_n, cs_exp);
                chk(bs_n == 1'b1, "R5 bs high in TMA2", bs_n, 1);
                @(negedge clk);
                // ST_T1
                chk(bs_n == 1'b0, "R5 bs low in T1", bs_n, 0);
                chk(rd_n == it.w, "R6 rd in T1", rd_n, it.w);
                chk(lwr_n == 1'b1, "R7 lwr high in T1", lwr_n, 1);
                chk(data_bus == (it.w ? it.wd : it.rv), "R6 R7 data in T1",
                    data_bus, it.w ? it.wd : it.rv);
                chk(rdwr == !it.w, "R7 rdwr in T1", rdwr, !it.w);
                @(negedge clk);
                // ST_T2
                chk(bs_n == 1'b1, "R5 bs high in T2", bs_n, 1);
                chk(rd_n == it.w, "R6 rd in T2", rd_n, it.w);
                chk(lwr_n == !it.w, "R7 lwr in T2", lwr_n, !it.w);
                chk(data_bus == (it.w ? it.wd : it.rv), "R6 R7 data in T2",
                    data_bus, it.w ? it.wd : it.rv);
                chk(cs_n == cs_exp, "R4 cs in T2", cs_n, cs_exp);
                @(negedge clk);
                // completion
                chk(done && !busy, "R2 done pulse", {done, busy}, 2'b10);
                chk(cs_n == 8'hFF && rdwr, "R4 cs released", cs_n, 8'hFF);
                if (!it.w) chk(rdata == it.rv, "R6 rdata", rdata, it.rv);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
        chk(cs_n == 8'hFF, "R1 cs", cs_n, 8'hFF);
        chk(ah_n && rd_n && lwr_n && bs_n && rdwr, "R1 strobes",
            {ah_n, rd_n, lwr_n, bs_n, rdwr}, 5'h1F);
        rst_n = 1'b1;
        @(negedge clk);

        issue(1'b1, 8'hA5, 8'h3C, 8'h00, 3'd3, 1'b0);
        issue(1'b0, 8'h12, 8'h00, 8'hC7, 3'd4, 1'b0);
        issue(1'b1, 8'hFF, 8'h81, 8'h00, 3'd7, 1'b0);
        issue(1'b0, 8'h00, 8'h00, 8'h5A, 3'd6, 1'b0);
        // R10 back-to-back chain issued in the done cycle
        issue(1'b0, 8'h77, 8'h00, 8'h0F, 3'd5, 1'b0);
        issue(1'b1, 8'h88, 8'hE1, 8'h00, 3'd5, 1'b0);
        // R9 mid-access disturbance
        issue(1'b1, 8'h4B, 8'h96, 8'h00, 3'd3, 1'b1);
        issue(1'b0, 8'hB4, 8'h00, 8'h69, 3'd7, 1'b1);
        @(negedge clk);

        // R8 areas outside the multiplexed range
        for (int k = 0; k < 3; k++) begin
            req = 1'b1; area = k[2:0]; we = 1'b1; addr = 8'h33;
            @(negedge clk);
            chk(!busy && cs_n == 8'hFF && ah_n, "R8 area ignored", {busy, cs_n}, 9'h0FF);
            req = 1'b0;
            @(negedge clk);
        end
        chk(rdata == 8'h69, "R8 rdata untouched", rdata, 8'h69);

        repeat (4) @(negedge clk);
        chk(seen == issued, "R9 access count", seen, issued);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        summary();
    end
endmodule